// File: doc/BRIEF.md
# Multi-Precision SIMD Dot-Product Accumulator

This unit is the multiply-reduce-accumulate datapath of a 32-bit processor core. It takes two 32-bit packed operand words and a 32-bit scalar accumulator value. It multiplies each pair of corresponding elements, adds up every product, and adds that sum to the accumulator. The work takes one clock cycle, and the 32-bit result appears in a register one cycle after the operation is accepted.

The element width is not part of the opcode. It is held in a small precision register that software writes, so one instruction encoding covers all four packings: two 16-bit lanes, four 8-bit lanes, eight 4-bit lanes or sixteen 2-bit lanes. The register is read when an operation is accepted. A write only affects operations accepted after the write cycle. Two separate controls select signed or unsigned reading for operand A and for operand B.

Top module: `simd_dotp_mac`

## Requirements
- R1: After reset, `out_valid` is 0, `result` is 0, and the precision register holds code 0 (two 16-bit lanes).
- R2: When `in_valid` is 1 at a rising edge, then after that edge `out_valid` is 1 and `result` equals `acc_in` plus the sum of the lane products of `op_a` and `op_b`.
- R3: Precision code 0 selects 2×16-bit lanes, code 1 selects 4×8-bit, code 2 selects 8×4-bit and code 3 selects 16×2-bit. Lane k of width W occupies bits [k·W+W-1 : k·W].
- R4: When `sign_a` (or `sign_b`) is 1, each lane of that operand is read as two's complement, with its top bit as the sign. The two controls act independently.
- R5: When a sign control is 0, the lanes of that operand are read as unsigned values.
- R6: The addition wraps modulo 2^32 and never saturates.
- R7: When `prec_wr_en` is 1 at an edge, the register takes `prec_wr_data`. An operation accepted at that same edge uses the old precision. Operations accepted at later edges use the new one.
- R8: When `in_valid` is 0 at an edge, `out_valid` goes to 0 after that edge and `result` keeps its value.
- R9: If either operand is all zeros, the result equals `acc_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prec_wr_en | input | 1 | Write strobe for the precision register |
| prec_wr_data | input | 2 | New precision code |
| in_valid | input | 1 | Operation is accepted at this edge |
| sign_a | input | 1 | Read operand A lanes as signed |
| sign_b | input | 1 | Read operand B lanes as signed |
| op_a | input | 32 | Packed operand A |
| op_b | input | 32 | Packed operand B |
| acc_in | input | 32 | Scalar accumulator input |
| out_valid | output | 1 | Result register holds a new value |
| result | output | 32 | Accumulated dot product |

## Verification
Every result is due exactly one rising edge after its operation is accepted. The bench drives each operation on a falling edge and reads `result` and `out_valid` on the following falling edge, half a period after the capture. A precision write lands on the edge where the write strobe is seen. For this reason the bench issues one operation on the same edge as a write, and another operation on the next edge, and expects the old and then the new lane width. After an idle edge, the bench checks that the previous result is unchanged.

// File: rtl/simd_dotp_pkg.sv
`timescale 1ns/1ps
package simd_dotp_pkg;
  localparam int unsigned PREC_W = 2;
  localparam int unsigned NPREC  = 4;

  typedef enum logic [PREC_W-1:0] {
    PREC_16 = 2'd0,
    PREC_8  = 2'd1,
    PREC_4  = 2'd2,
    PREC_2  = 2'd3
  } prec_e;

  // Lane width for precision code p, given the widest lane.
  function automatic int unsigned lane_width(int unsigned max_w, int unsigned p);
    return max_w >> p;
  endfunction

  // Extend a lane to one extra bit: sign copy or zero.
  function automatic logic [16:0] extend_lane(logic [15:0] v, int unsigned w, logic sgn);
    logic [16:0] r;
    r = {1'b0, v};
    if (sgn && v[w-1]) begin
      for (int i = 0; i < 17; i++) if (i >= int'(w)) r[i] = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/simd_dotp_prec_reg.sv
`timescale 1ns/1ps
module simd_dotp_prec_reg
  import simd_dotp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PREC_W-1:0] wr_data,
  output logic [PREC_W-1:0] prec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     prec_q <= PREC_16;
    else if (wr_en) prec_q <= wr_data;
  end
endmodule

// File: rtl/simd_dotp_lanes.sv
`timescale 1ns/1ps
module simd_dotp_lanes
  import simd_dotp_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned W  = 8
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          sign_a,
  input  logic          sign_b,
  output logic [DW-1:0] dot
);
  localparam int unsigned LANES = DW / W;
  localparam int unsigned PW    = 2 * W + 2;

  logic [DW-1:0] lane_prod [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [16:0] ea_full, eb_full;
    logic signed [W:0]    ea, eb;
    logic signed [PW-1:0] prod;
    always_comb begin
      ea_full = extend_lane(16'(op_a[k*W +: W]), W, sign_a);
      eb_full = extend_lane(16'(op_b[k*W +: W]), W, sign_b);
    end
    assign ea   = ea_full[W:0];
    assign eb   = eb_full[W:0];
    assign prod = PW'(ea) * PW'(eb);
    if (PW >= DW) begin : g_trunc
      assign lane_prod[k] = prod[DW-1:0];
    end else begin : g_sext
      assign lane_prod[k] = {{(DW-PW){prod[PW-1]}}, prod};
    end
  end

  always_comb begin
    dot = '0;
    for (int k = 0; k < LANES; k++) dot = dot + lane_prod[k];
  end
endmodule

// File: rtl/simd_dotp_mac.sv
`timescale 1ns/1ps
module simd_dotp_mac
  import simd_dotp_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prec_wr_en,
  input  logic [PREC_W-1:0] prec_wr_data,
  input  logic              in_valid,
  input  logic              sign_a,
  input  logic              sign_b,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic [DW-1:0]     acc_in,
  output logic              out_valid,
  output logic [DW-1:0]     result
);
  localparam int unsigned MAX_W = DW / 2;

  logic [PREC_W-1:0] prec_q;
  logic [DW-1:0]     dot_by_prec [NPREC];
  logic [DW-1:0]     dot_sel;
  logic [DW-1:0]     next_result;

  simd_dotp_prec_reg u_prec (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (prec_wr_en),
    .wr_data (prec_wr_data),
    .prec_q  (prec_q)
  );

  for (genvar p = 0; p < NPREC; p++) begin : g_prec
    simd_dotp_lanes #(.DW(DW), .W(lane_width(MAX_W, p))) u_lanes (
      .op_a   (op_a),
      .op_b   (op_b),
      .sign_a (sign_a),
      .sign_b (sign_b),
      .dot    (dot_by_prec[p])
    );
  end

  assign dot_sel     = dot_by_prec[prec_q];
  assign next_result = acc_in + dot_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/simd_dotp_mac_chk.sv
`timescale 1ns/1ps
module simd_dotp_mac_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          prec_wr_en,
  input logic [1:0]    prec_wr_data,
  input logic [1:0]    prec_q,
  input logic          in_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [DW-1:0] acc_in,
  input logic          out_valid,
  input logic [DW-1:0] result
);
  wire accepted   = in_valid;
  wire zero_oper  = (op_a == '0) || (op_b == '0);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) accepted |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n) !accepted |=> !out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !accepted |=> $stable(result)); // R8
  AST_ZERO_GIVES_ACC: assert property (@(posedge clk) disable iff (!rst_n) (accepted && zero_oper) |=> result == $past(acc_in)); // R9
  AST_PREC_LOADS: assert property (@(posedge clk) disable iff (!rst_n) prec_wr_en |=> prec_q == $past(prec_wr_data)); // R7
  AST_PREC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n) !prec_wr_en |=> $stable(prec_q)); // R7
endmodule

bind simd_dotp_mac simd_dotp_mac_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prec_wr_en(prec_wr_en), .prec_wr_data(prec_wr_data),
  .prec_q(prec_q), .in_valid(in_valid), .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
  .out_valid(out_valid), .result(result)
);

// File: tb/simd_dotp_mac_bench.sv
`timescale 1ns/1ps
module simd_dotp_mac_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prec_wr_en = 1'b0;
  logic [1:0]  prec_wr_data = '0;
  logic        in_valid = 1'b0;
  logic        sign_a = 1'b0, sign_b = 1'b0;
  logic [31:0] op_a = '0, op_b = '0, acc_in = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_dotp_mac u_simd_dotp_mac (
    .clk(clk), .rst_n(rst_n), .prec_wr_en(prec_wr_en), .prec_wr_data(prec_wr_data),
    .in_valid(in_valid), .sign_a(sign_a), .sign_b(sign_b), .op_a(op_a), .op_b(op_b),
    .acc_in(acc_in), .out_valid(out_valid), .result(result)
  );

  // Arithmetic model: lane value as integer, signed by subtracting 2^W.
  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, logic [31:0] acc,
                                        int p, bit sa, bit sb);
    int  w = 16 >> p;
    longint s = longint'(acc);
    longint span = longint'(1) << w;
    for (int k = 0; k < 32 / w; k++) begin
      longint x = longint'((a >> (k * w))) % span;
      longint y = longint'((b >> (k * w))) % span;
      if (sa && x >= span / 2) x -= span;
      if (sb && y >= span / 2) y -= span;
      s += x * y;
    end
    return s[31:0];
  endfunction

  function automatic logic [31:0] replicate(longint v, int w);
    logic [31:0] m = '0;
    for (int k = 0; k < 32 / w; k++) m |= 32'(v) << (k * w);
    return m;
  endfunction

  function automatic logic [31:0] pattern(int idx, int p);
    int w = 16 >> p;
    case (idx)
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return replicate(longint'(1) << (w - 1), w);
      3: return replicate((longint'(1) << (w - 1)) - 1, w);
      default: return $urandom;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_prec(int p);
    @(negedge clk);
    prec_wr_en = 1'b1; prec_wr_data = 2'(p);
    @(negedge clk);
    prec_wr_en = 1'b0;
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, logic [31:0] acc, int p,
                        bit sa, bit sb, string req);
    logic [31:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; acc_in = acc; sign_a = sa; sign_b = sb; in_valid = 1'b1;
    exp = model(a, b, acc, p, sa, sb);
    @(negedge clk);
    in_valid = 1'b0;
    check(result == exp, req, result, exp);
    check(out_valid == 1'b1, "R2 out_valid", 32'(out_valid), 32'd1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state, precision defaults to two 16-bit lanes
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    check(result == 32'h0, "R1 result", result, 32'h0);
    run_op(32'h0003_0002, 32'h0005_0007, 32'd0, 0, 0, 0, "R1 default precision");

    // R3 R4 R5: sweep all precisions, sign combinations and extreme patterns
    for (int p = 0; p < 4; p++) begin
      set_prec(p);
      for (int sc = 0; sc < 4; sc++) begin
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++)
            run_op(pattern(i, p), pattern(j, p), $urandom, p, sc[0], sc[1],
                   sc == 0 ? "R3 R5 unsigned lanes" : "R3 R4 signed lanes");
        for (int r = 0; r < 12; r++)
          run_op($urandom, $urandom, $urandom, p, sc[0], sc[1], "R3 R4 R5 random");
      end
      // R9: zero operand returns the accumulator
      run_op(32'h0, $urandom, 32'h1234_5678, p, 1, 1, "R9 zero operand");
    end

    // R6: wrap without saturation, 1*1 + 1*1 + 0xFFFFFFFF = 1
    set_prec(0);
    run_op(32'h0001_0001, 32'h0001_0001, 32'hFFFF_FFFF, 0, 0, 0, "R6 wrap");
    check(result == 32'h1, "R6 wrap constant", result, 32'h1);
    run_op(32'h7FFF_7FFF, 32'h7FFF_7FFF, 32'h7FFF_FFFF, 0, 1, 1, "R6 wrap positive");

    // R7: write on the same edge as an operation; that operation uses the old precision
    @(negedge clk);
    prec_wr_en = 1'b1; prec_wr_data = 2'd3;
    op_a = 32'hFFFF_FFFF; op_b = 32'hFFFF_FFFF; acc_in = 32'd0;
    sign_a = 1'b0; sign_b = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    prec_wr_en = 1'b0;
    check(result == model(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0), "R7 old precision",
          result, model(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0));
    // operation on the next edge uses the new (2-bit) precision: 16*9 = 144
    @(negedge clk);
    in_valid = 1'b0;
    check(result == 32'd144, "R7 new precision", result, 32'd144);

    // R8: idle edge keeps result and drops out_valid
    held = result;
    op_a = $urandom; op_b = $urandom; acc_in = $urandom;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid", 32'(out_valid), 32'd0);
    check(result == held, "R8 hold", result, held);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule